// File: doc/BRIEF.md
# Size-Agnostic Control Register Target

This block answers the system bus for a small file of 32-bit control registers. Every transfer is handled as a whole 32-bit word, whatever its size field says. A read always returns the full word at the word-aligned address, and the requester picks out the lane it wants. A write always stores the full bus word exactly as driven. Because of this, a narrow store leaves the requester's lane-shifted data in the register, including whatever bytes leaked into the other lanes.

A 64-bit transfer arrives as two consecutive handshakes. On a read, both beats carry the same word, so the doubleword holds that word in both halves. On a write, the first beat, which is the upper word, is stored and the second beat is thrown away. Accesses complete in the cycle they are presented. Addresses outside the register window are left unanswered. Word slots inside the window beyond the implemented registers read as zero.

Top module: `regbus_target`

## Requirements
- R1: For a request inside the window (address bits above the window match `BASE_ADDR`), `resp_ready` is high in the same cycle as `req_valid`, with no wait cycles.
- R2: For a request outside the window, `resp_ready` stays low and no register changes.
- R3: A read of a non-doubleword size (`req_size` 0 = byte, 1 = halfword, 2 = word) returns on `resp_rdata`, in the same cycle, the full 32-bit register at address bits [WIN_LSB-1:2], ignoring address bits [1:0] and the size.
- R4: A write of a non-doubleword size stores all 32 bits of `req_wdata` verbatim into the register at the word-aligned address, ignoring address bits [1:0] and the size. For example, a byte store to offset 1 that drives 0x56780000 leaves 0x56780000 in the register.
- R5: A doubleword read (`req_size` = 3) takes two handshakes, and both beats return the same 32-bit word.
- R6: In a doubleword write, the first beat's data is stored and the second beat's data is discarded.
- R7: Word slots inside the window at index NUM_REGS or above read as zero and ignore writes.
- R8: After reset, every register is zero and the next doubleword handshake is treated as a first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code, 0 = byte, 1 = half, 2 = word, 3 = doubleword |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word as driven on the bus |
| resp_ready | output | 1 | Request accepted this cycle |
| resp_rdata | output | 32 | Read word; zero when not ready |
| reg_view | output | NUM_REGS*32 | Current contents of all registers, register 0 in the low bits |

## Verification
The assertions check on every cycle that out-of-window requests are never claimed, that an accepted write lands verbatim one edge later, that a second doubleword beat leaves every register unchanged, and that a first doubleword beat arms the second. Reads of unimplemented slots are also checked as zero on every cycle. Only the bench's scenarios can show the end-to-end effects: the leaked lane bytes of a byte store, the duplicated word across a doubleword read, and register contents that stay intact across long mixed sequences of sizes and offsets.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
    localparam int WORD_W = 32;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/regbus_decode.sv
module regbus_decode #(
    parameter int ADDR_W = 32,
    parameter int NUM_REGS = 16,
    parameter int WIN_WORDS = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0460_0000
) (
    input  logic [ADDR_W-1:2]              word_addr,
    output logic                           in_window,
    output logic                           implemented,
    output logic [$clog2(NUM_REGS)-1:0]    reg_idx
);
    localparam int WIN_IDX_W = $clog2(WIN_WORDS);
    localparam int WIN_LSB   = WIN_IDX_W + 2;
    localparam int REG_IDX_W = $clog2(NUM_REGS);

    logic [WIN_IDX_W-1:0] slot;

    always_comb begin
        slot        = word_addr[WIN_LSB-1:2];
        in_window   = (word_addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
        implemented = (int'(slot) < NUM_REGS);
        reg_idx     = slot[REG_IDX_W-1:0];
    end
endmodule

// File: rtl/regbus_beat.sv
module regbus_beat (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic is_dword,
    output logic second_beat
);
    typedef struct packed {
        logic second;
    } beat_state_t;

    beat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            if (is_dword) st_d.second = !st_q.second;
            else          st_d.second = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign second_beat = st_q.second;

    // R5 / R6: a first doubleword beat arms the second beat
    p_dword_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_dword && !second_beat) |=> second_beat);
    // R6: the second beat returns the tracker to first-beat state
    p_pair_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && second_beat) |=> !second_beat);
endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile
    import regbus_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [$clog2(NUM_REGS)-1:0]      wr_idx,
    input  logic [WORD_W-1:0]                wr_data,
    input  logic [$clog2(NUM_REGS)-1:0]      rd_idx,
    output logic [WORD_W-1:0]                rd_word,
    output logic [NUM_REGS*WORD_W-1:0]       regs_flat
);
    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] regs;
    } rf_state_t;

    rf_state_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr_en) rf_d.regs[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        rd_word   = rf_q.regs[rd_idx];
        regs_flat = rf_q.regs;
    end

    // R4: an accepted write lands verbatim one edge later
    p_write_verbatim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rf_q.regs[$past(wr_idx)] == $past(wr_data)));
    // R7 / R2: no write strobe means no register moves
    p_hold_without_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rf_q.regs));
endmodule

// File: rtl/regbus_target.sv
module regbus_target
    import regbus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_REGS = 16,
    parameter int WIN_WORDS = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0460_0000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [1:0]                   req_size,
    input  logic                         req_write,
    input  logic [31:0]                  req_wdata,
    output logic                         resp_ready,
    output logic [31:0]                  resp_rdata,
    output logic [NUM_REGS*32-1:0]       reg_view
);
    localparam int REG_IDX_W = $clog2(NUM_REGS);

    logic                 in_window, implemented, second_beat, fire, is_dword, wr_en;
    logic [REG_IDX_W-1:0] reg_idx;
    logic [WORD_W-1:0]    rd_word;
    wire                  unused_lane_bits = ^req_addr[1:0];

    regbus_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
        .WIN_WORDS(WIN_WORDS), .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .word_addr  (req_addr[ADDR_W-1:2]),
        .in_window  (in_window),
        .implemented(implemented),
        .reg_idx    (reg_idx)
    );

    always_comb begin
        is_dword   = (acc_size_e'(req_size) == SZ_DWORD);
        resp_ready = req_valid && in_window;
        fire       = resp_ready;
        wr_en      = fire && req_write && implemented && !second_beat;
        resp_rdata = (fire && implemented && !req_write) ? rd_word : '0;
    end

    regbus_beat u_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .is_dword   (is_dword),
        .second_beat(second_beat)
    );

    regbus_regfile #(.NUM_REGS(NUM_REGS)) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (reg_idx),
        .wr_data  (req_wdata),
        .rd_idx   (reg_idx),
        .rd_word  (rd_word),
        .regs_flat(reg_view)
    );

    // R2: requests outside the window are never claimed
    p_no_claim_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_window) |-> !resp_ready);
    // R1: in-window requests are accepted without a wait cycle
    p_same_cycle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_window) |-> resp_ready);
    // R6: the second doubleword write beat changes nothing
    p_second_beat_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_write && second_beat) |=> $stable(reg_view));
    // R7: unimplemented slots read zero
    p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !implemented) |-> (resp_rdata == '0));
endmodule

// File: tb/regbus_target_tb.sv
module regbus_target_tb;
    localparam int NREG = 16;
    localparam logic [31:0] BASE = 32'h0460_0000;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic [1:0] req_size = 0;
    logic resp_ready;
    logic [31:0] resp_rdata;
    logic [NREG*32-1:0] reg_view;

    int n_checks = 0, n_fail = 0;
    logic [31:0] model [NREG];
    bit second_m = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    regbus_target u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .resp_ready(resp_ready), .resp_rdata(resp_rdata), .reg_view(reg_view)
    );

    function automatic bit hit_f(logic [31:0] a);
        return a[31:7] == BASE[31:7];
    endfunction
    function automatic int slot_f(logic [31:0] a);
        return int'(a[6:2]);
    endfunction
    function automatic logic [31:0] exp_read(logic [31:0] a);
        if (!hit_f(a) || slot_f(a) >= NREG) return 32'h0;
        return model[slot_f(a)];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs(string req);
        for (int i = 0; i < NREG; i++) chk(req, reg_view[i*32 +: 32], model[i]);
    endtask

    // one beat: drive at negedge, check combinational response, clock, update model
    task automatic beat(logic [31:0] a, logic [1:0] sz, logic wr, logic [31:0] d, string req);
        bit h;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_size = sz; req_write = wr; req_wdata = d;
        #1;
        h = hit_f(a);
        chk(h ? "R1" : "R2", {31'b0, resp_ready}, {31'b0, h});
        if (h && !wr) chk(req, resp_rdata, exp_read(a));
        @(posedge clk);
        if (h) begin
            if (wr && !second_m && slot_f(a) < NREG) model[slot_f(a)] = d;
            second_m = (sz == 2'd3) ? !second_m : 1'b0;
        end
        @(negedge clk);
        req_valid = 0;
        #1;
        check_regs(req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NREG; i++) model[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        check_regs("R8");
        rst_n = 1;

        // R4: byte store at offset 1 keeps the shifted word verbatim
        beat(BASE + 32'h11, 2'd0, 1, 32'h5678_0000, "R4");
        chk("R4", reg_view[4*32 +: 32], 32'h5678_0000);
        // R3: halfword read at offset 2 returns the full word
        beat(BASE + 32'h12, 2'd1, 0, 32'h0, "R3");
        // R6: doubleword write keeps first beat only
        beat(BASE + 32'h20, 2'd3, 1, 32'hAAAA_1111, "R6");
        beat(BASE + 32'h20, 2'd3, 1, 32'hBBBB_2222, "R6");
        chk("R6", reg_view[8*32 +: 32], 32'hAAAA_1111);
        // R5: doubleword read duplicates the word on both beats
        beat(BASE + 32'h20, 2'd3, 0, 32'h0, "R5");
        beat(BASE + 32'h20, 2'd3, 0, 32'h0, "R5");
        // R7: unimplemented slot ignores writes and reads zero
        beat(BASE + 32'h50, 2'd2, 1, 32'hDEAD_BEEF, "R7");
        beat(BASE + 32'h50, 2'd2, 0, 32'h0, "R7");
        // R2: outside the window is unclaimed and changes nothing
        beat(32'h0450_0010, 2'd2, 1, 32'hFFFF_FFFF, "R2");
        beat(BASE + 32'h80, 2'd2, 1, 32'h1234_5678, "R2");

        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            logic [1:0] sz;
            logic wr;
            a  = (($urandom % 8) == 0) ? $urandom : (BASE | ($urandom & 32'h7F));
            sz = 2'($urandom);
            wr = 1'($urandom);
            if (sz == 2'd3) begin
                a = {a[31:3], 3'b000};
                beat(a, sz, wr, $urandom, wr ? "R6" : "R5");
                if (hit_f(a)) beat(a, sz, wr, $urandom, wr ? "R6" : "R5");
            end else begin
                beat(a, sz, wr, $urandom, wr ? "R4" : "R3");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule